// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how many cycles of a fast reference clock fit into a chosen number of periods of a slow, free-running clock. Everything runs on the fast clock. The slow clock comes in as a plain input. It is resynchronised and its rising edges are detected in the fast domain.

Software writes the number of slow periods it wants to measure. It then raises a start bit. Only the 0-to-1 transition of that bit begins a measurement. While the measurement runs, the ready flag is low and the result reads zero. When the programmed number of slow periods has elapsed, the block drops the count of fast cycles into the result and sets ready. Software turns that count into a frequency ratio.

Top module: `slow_clk_meter`

## Requirements
- R1: A 0-to-1 transition of `cal_start`, sampled on `clk`, begins a measurement. Holding `cal_start` high starts nothing further. A new transition during a running measurement abandons it and starts again.
- R2: The period count `period_cnt` is PERIOD_W bits wide (default 10, so up to 1023 periods). It is captured on the cycle of the start transition, and later changes to it do not affect the running measurement.
- R3: For a non-zero period count N, the result equals the number of fast cycles from the first detected slow rising edge after the start to the N-th detected rising edge after it. A regular slow clock of period P fast cycles therefore gives N*P.
- R4: After reset, `ready` is 0 and `result` is 0. While a measurement runs, `ready` is 0 and `result` is 0.
- R5: The slow clock passes through a two-flop synchroniser before edge detection. Suppose `clk` edge e is the first to sample `slow_clk` high after a low sample. If that rising edge completes the measurement, `ready` goes high just after edge e+2.
- R6: The result saturates at 2^RESULT_W-1 instead of wrapping.
- R7: A start transition with a period count of 0 finishes at once: `ready` is 1 and `result` is 0 after the next `clk` edge.
- R8: Once `ready` is 1, both `ready` and `result` keep their values until the next start transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Start control; its rising edge begins a measurement |
| period_cnt | input | PERIOD_W | Number of slow periods to measure |
| slow_clk | input | 1 | Slow clock to be measured, asynchronous to `clk` |
| result | output | RESULT_W | Fast-cycle count over the programmed periods |
| ready | output | 1 | 1 when a finished result is held, 0 otherwise |

## Verification
The properties assume that `cal_start` and `period_cnt` are synchronous to `clk`. They also assume that the slow clock stays high and low for at least two fast cycles each, so that every slow rising edge shows up as one detect pulse. The stimulus drives every input on the falling edge of `clk`. It builds the slow clock from a half-period counter of at least two fast cycles. This keeps each slow edge cleanly separated and lets a per-cycle reference model predict the exact detection cycle.

// File: rtl/scm_pkg.sv
// Shared types for the slow clock calibration counter.
package scm_pkg;

    // Measurement sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no measurement running
        ST_ARM   = 2'd1,  // started, waiting for first slow rising edge
        ST_COUNT = 2'd2   // counting fast cycles between slow edges
    } scm_state_e;

endpackage

// File: rtl/scm_start_edge.sv
// Start edge detector.
// Turns the level of the start control into a one-cycle pulse on its
// 0-to-1 transition. Assumes the control is synchronous to clk.
module scm_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start_lvl,
    output logic start_pulse
);

    logic start_q;

    // Remember last cycle's level of the start control.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_lvl;
    end

    assign start_pulse = start_lvl & ~start_q;

endmodule

// File: rtl/scm_slow_sync.sv
// Slow clock synchroniser and rising edge detector.
// Passes the asynchronous slow clock through SYNC_STAGES flops, then
// compares the last stage with one more delayed copy. Assumes the slow
// clock stays high and low for at least two fast cycles each.
module scm_slow_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic slow_rise
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the slow clock through the synchroniser and edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], slow_clk};
    end

    assign slow_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

endmodule

// File: rtl/scm_period_counter.sv
// Measurement sequencer and saturating fast-cycle counter.
// Captures the period count on a start pulse and arms on the first slow
// edge. It then counts fast cycles until the programmed number of slow
// edges has passed, and latches the count as the result. Assumes
// start_pulse and slow_rise are single-cycle pulses in the clk domain.
module scm_period_counter
    import scm_pkg::*;
#(
    parameter int PERIOD_W = 10,
    parameter int RESULT_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_pulse,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                slow_rise,
    output logic [RESULT_W-1:0] result,
    output logic                done,
    output logic                busy
);

    localparam logic [RESULT_W-1:0] CNT_MAX  = '1;
    localparam logic [PERIOD_W-1:0] REM_LAST = PERIOD_W'(1);

    scm_state_e          state;
    logic [PERIOD_W-1:0] remaining;
    logic [RESULT_W-1:0] cnt;
    logic [RESULT_W-1:0] cnt_next;

    // Saturating increment of the running count.
    always_comb begin
        cnt_next = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
    end

    // Sequence a measurement: capture, arm, count, latch result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            cnt       <= '0;
            result    <= '0;
            done      <= 1'b0;
        end else if (start_pulse) begin
            result    <= '0;
            cnt       <= '0;
            remaining <= period_in;
            if (period_in == '0) begin
                state <= ST_IDLE;
                done  <= 1'b1;
            end else begin
                state <= ST_ARM;
                done  <= 1'b0;
            end
        end else begin
            unique case (state)
                ST_ARM: begin
                    if (slow_rise) begin
                        state <= ST_COUNT;
                        cnt   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (slow_rise && remaining == REM_LAST) begin
                        state  <= ST_IDLE;
                        result <= cnt_next;
                        done   <= 1'b1;
                    end else begin
                        cnt <= cnt_next;
                        if (slow_rise) remaining <= remaining - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/slow_clk_meter.sv
// Slow clock calibration counter, top level.
// Counts fast clock cycles over a programmed number of slow clock periods.
// The measurement begins on the rising edge of the start control. Assumes
// the start control and period count are synchronous to clk, and that
// slow_clk is a free-running clock much slower than clk.
module slow_clk_meter #(
    parameter int PERIOD_W    = 10,
    parameter int RESULT_W    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_start,
    input  logic [PERIOD_W-1:0] period_cnt,
    input  logic                slow_clk,
    output logic [RESULT_W-1:0] result,
    output logic                ready
);

    logic start_pulse;
    logic slow_rise;
    logic busy;

    scm_start_edge u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_lvl   (cal_start),
        .start_pulse (start_pulse)
    );

    scm_slow_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .slow_rise (slow_rise)
    );

    scm_period_counter #(
        .PERIOD_W (PERIOD_W),
        .RESULT_W (RESULT_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .period_in   (period_cnt),
        .slow_rise   (slow_rise),
        .result      (result),
        .done        (ready),
        .busy        (busy)
    );

endmodule

// File: rtl/scm_checker.sv
// Property checker for the slow clock calibration counter.
// Observes the top-level ports and the pulses passed between submodules.
// Assumes a start pulse and a slow rising edge are each one cycle wide.
module scm_checker #(
    parameter int PERIOD_W = 10,
    parameter int RESULT_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_pulse,
    input logic                slow_rise,
    input logic                busy,
    input logic [PERIOD_W-1:0] period_cnt,
    input logic [RESULT_W-1:0] result,
    input logic                ready
);

    // R1: a start edge with a non-zero count begins a running measurement.
    p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse && period_cnt != '0 |=> busy && !ready);

    // R4: while running, ready is low and the result reads zero.
    p_busy_hides_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready && result == '0);

    // R5: ready only rises after a slow edge or a zero-count start.
    p_finish_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(slow_rise) || $past(start_pulse));

    // R6: a finished non-zero measurement never reports a wrapped zero.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) && !$past(start_pulse) |-> result != '0);

    // R7: a zero count finishes on the next edge with a zero result.
    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse && period_cnt == '0 |=> ready && result == '0);

    // R8: a finished result holds until the next start edge.
    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !start_pulse |=> ready && $stable(result));

endmodule

bind slow_clk_meter scm_checker #(
    .PERIOD_W (PERIOD_W),
    .RESULT_W (RESULT_W)
) u_scm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .slow_rise   (slow_rise),
    .busy        (busy),
    .period_cnt  (period_cnt),
    .result      (result),
    .ready       (ready)
);

// File: tb/test_slow_clk_meter.sv
// Bench: per-cycle behavioural model plus named checks.
module test_slow_clk_meter;

    localparam int PW   = 10;
    localparam int RW   = 12;
    localparam int RMAX = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_start = 1'b0;
    logic [PW-1:0] period_cnt = '0;
    logic          slow_clk = 1'b0;
    logic [RW-1:0] result;
    logic          ready;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int slow_half = 0;
    int slow_ctr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    slow_clk_meter #(.PERIOD_W(PW), .RESULT_W(RW)) i_slow_clk_meter (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .period_cnt(period_cnt), .slow_clk(slow_clk),
        .result(result), .ready(ready)
    );

    // Behavioural reference model.
    bit q[$];
    int m_st, m_rem, m_cnt, m_res;
    bit m_done, m_prev;

    always @(posedge clk) begin
        bit rise, sp;
        if (!rst_n) begin
            q = '{0, 0, 0};
            m_st = 0; m_rem = 0; m_cnt = 0; m_res = 0; m_done = 0; m_prev = 0;
        end else begin
            rise = q[1] && !q[2];
            sp = cal_start && !m_prev;
            m_prev = cal_start;
            if (sp) begin
                m_res = 0;
                if (period_cnt == 0) begin m_done = 1; m_st = 0; end
                else begin m_done = 0; m_st = 1; m_rem = period_cnt; end
            end else if (m_st == 1) begin
                if (rise) begin m_st = 2; m_cnt = 0; end
            end else if (m_st == 2) begin
                if (rise && m_rem == 1) begin
                    m_res = (m_cnt + 1 > RMAX) ? RMAX : m_cnt + 1;
                    m_done = 1; m_st = 0;
                end else begin
                    m_cnt = (m_cnt + 1 > RMAX) ? RMAX : m_cnt + 1;
                    if (rise) m_rem = m_rem - 1;
                end
            end
            q.push_front(slow_clk);
            void'(q.pop_back());
        end
    end

    // Per-cycle comparison against the model (R3, R5 timing).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            compared++;
            if (result !== RW'(m_res) || ready !== m_done) begin
                mismatched++;
                $display("FAIL R3/R5 cycle %0d: result=%0d ready=%0b expected result=%0d ready=%0b",
                         cyc, result, ready, m_res, m_done);
            end
        end
    end

    // Slow clock generator with a programmable half period.
    always @(negedge clk) begin
        if (slow_half > 0) begin
            slow_ctr++;
            if (slow_ctr >= slow_half) begin
                slow_clk <= ~slow_clk;
                slow_ctr = 0;
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(int n);
        @(negedge clk);
        period_cnt = PW'(n);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset ready", ready, 0);
        check("R4 reset result", result, 0);

        // R3: single period of 10 fast cycles.
        slow_half = 5;
        repeat (20) @(negedge clk);
        pulse_start(1);
        check("R4 ready low while running", ready, 0);
        wait_ready();
        check("R3 one period", result, 10);

        // R3: five periods of 8 fast cycles.
        slow_half = 4;
        repeat (10) @(negedge clk);
        pulse_start(5);
        wait_ready();
        check("R3 five periods", result, 40);

        // R2: period count changed during the run is ignored.
        slow_half = 3;
        pulse_start(4);
        period_cnt = PW'(1);
        wait_ready();
        check("R2 count captured at start", result, 24);

        // R1/R8: holding start high does not restart.
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        check("R1 edge while done", ready, 0);
        wait_ready();
        check("R3 after held start", result, 6);
        repeat (60) @(negedge clk);
        check("R1 held start no restart", ready, 1);
        check("R8 result held", result, 6);
        cal_start = 1'b0;

        // R7: zero period finishes immediately.
        pulse_start(0);
        check("R7 zero count ready", ready, 1);
        check("R7 zero count result", result, 0);

        // R1: restart mid measurement.
        slow_half = 5;
        pulse_start(6);
        repeat (30) @(negedge clk);
        check("R1 running before restart", ready, 0);
        pulse_start(2);
        wait_ready();
        check("R1 restart result", result, 20);

        // R6: saturation (50 periods of 100 cycles exceeds 4095).
        slow_half = 50;
        pulse_start(50);
        wait_ready();
        check("R6 saturated result", result, RMAX);

        // R2: maximum period count 1023 at 4 cycles each.
        slow_half = 2;
        pulse_start(1023);
        wait_ready();
        check("R2 max period count", result, 4092);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule